// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Start Validation and Break Detection

This block turns an asynchronous serial line into parallel characters. A sample-enable input marks each period of the receive clock. That clock runs at 1, 16 or 64 times the bit rate, as set by a rate selector. The line first passes through a synchronizer. The receiver then waits for a falling edge. In the 16x and 64x modes it checks the line again at the middle of the start bit, and treats a line that has returned high as a glitch.

Once a start bit is confirmed, the receiver samples 5 to 8 data bits (least significant first), an optional parity bit and the stop bit, each at its centre. A finished character lands in a holding register and raises a ready flag. The host clears that flag with a read strobe.

Parity, framing and overrun errors are sticky until an error-clear strobe. A separate counter watches for the line being held low for two whole frames and raises a break indication. The break indication drops again once the line is high.

Top module: `async_rx_core`

## Requirements
- R1: Data bits are received least significant bit first. `char_len` selects 5 (0), 6 (1), 7 (2) or 8 (3) data bits. `rx_data` holds the character right-justified with all unused upper bits zero.
- R2: `rate_sel` 0 samples once per bit (1x), 1 uses 16 sample periods per bit and 2 or 3 uses 64. Characters are received correctly in every mode.
- R3: In the 16x and 64x modes the start bit is sampled again on the 8th (or 32nd) sample period after the falling edge. If the line is high there, no character is produced and the receiver returns to idle.
- R4: `rx_ready` rises the cycle after a character completes. It stays set until a cycle in which `rd_ack` is high and no character completes.
- R5: When `par_en` is 1, a parity bit follows the data. `par_odd` 0 means even parity, 1 means odd parity. A mismatch sets `par_err`. When `par_en` is 0, `par_err` is never set.
- R6: A stop bit sampled low sets `frm_err`.
- R7: A character that completes while `rx_ready` is still set, with no `rd_ack` in that cycle, sets `ovr_err`. The holding register then takes the newer character. `rx_data` does not change except when a character completes.
- R8: `err_clr` clears `par_err`, `frm_err` and `ovr_err` on the next clock. If an error is set in the same cycle, the set wins. `err_clr` does not affect `rx_ready`.
- R9: `brk_det` rises once the synchronized line has been low for 2 × (char_len+7+par_en) × rate sample periods. It drops within three clocks of the line going high.
- R10: After synchronous reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| samp_en | input | 1 | One-cycle pulse per receive-clock period |
| rxd | input | 1 | Serial line, idle high |
| rate_sel | input | 2 | Sample periods per bit: 0=1, 1=16, 2/3=64 |
| char_len | input | 2 | Data bits minus five |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 = odd parity, 0 = even |
| rd_ack | input | 1 | Host has taken the character |
| err_clr | input | 1 | Clear sticky error flags |
| rx_data | output | 8 | Received character, right-justified |
| rx_ready | output | 1 | Character waiting |
| par_err | output | 1 | Parity error seen |
| frm_err | output | 1 | Stop bit was low |
| ovr_err | output | 1 | Character lost to overrun |
| brk_det | output | 1 | Line held low for two frames |

## Verification
The bench sends short characters and checks that they come out right-justified with clean upper bits. A wrong shift amount would leave stale bits there or move the data.

A four-period low pulse must vanish without a character. A receiver that trusted the edge alone would hand over a 0xFF-style junk byte.

Two characters sent without a read must set the overrun flag and leave the second byte visible. The bench also checks that clearing errors leaves the ready flag alone.

The break counter is probed a few sample periods either side of its two-frame threshold, and again just after the line returns high. This catches an off-by-frame threshold or a flag that never drops.

// File: rtl/rx_pkg.sv
package rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_t;

  localparam logic [1:0] RATE_X1  = 2'd0;
  localparam logic [1:0] RATE_MID = 2'd1;
endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rxd,
  output logic rxd_s
);
  logic [STAGES-1:0] sr;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sr <= '1;
        else     sr <= rxd;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sr <= '1;
        else     sr <= {sr[STAGES-2:0], rxd};
      end
    end
  endgenerate

  assign rxd_s = sr[STAGES-1];
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm import rx_pkg::*; #(
  parameter int MID_DIV = 16,
  parameter int HI_DIV  = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       samp_en,
  input  logic       line,
  input  logic [1:0] rate_sel,
  input  logic [1:0] char_len,
  input  logic       par_en,
  input  logic       par_odd,
  output logic       done,
  output logic [7:0] data,
  output logic       pe,
  output logic       fe
);
  localparam int CW = $clog2(HI_DIV);

  rx_state_t   st;
  logic [CW-1:0] cnt, div_m1, half_m1;
  logic [2:0]  bitn, last_bit;
  logic [7:0]  sh, aligned;
  logic [1:0]  shamt;
  logic        pbit, is_x1, full_tick, half_tick;

  always_comb begin
    is_x1 = (rate_sel == RATE_X1);
    if (rate_sel == RATE_MID) begin
      div_m1  = CW'(MID_DIV - 1);
      half_m1 = CW'(MID_DIV / 2 - 1);
    end else if (is_x1) begin
      div_m1  = '0;
      half_m1 = '0;
    end else begin
      div_m1  = CW'(HI_DIV - 1);
      half_m1 = CW'(HI_DIV / 2 - 1);
    end
    full_tick = samp_en && (cnt == div_m1);
    half_tick = samp_en && (cnt == half_m1);
    last_bit  = {1'b0, char_len} + 3'd4;
    shamt     = 2'd3 - char_len;
    aligned   = sh >> shamt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= ST_IDLE;
      cnt  <= '0;
      bitn <= '0;
      sh   <= '0;
      pbit <= 1'b0;
      done <= 1'b0;
      data <= '0;
      pe   <= 1'b0;
      fe   <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (samp_en && !line) begin
            cnt  <= '0;
            bitn <= '0;
            st   <= is_x1 ? ST_DATA : ST_START;
          end
        end
        ST_START: begin
          if (half_tick) begin
            cnt <= '0;
            st  <= line ? ST_IDLE : ST_DATA;
          end else if (samp_en) begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_DATA: begin
          if (full_tick) begin
            cnt  <= '0;
            sh   <= {line, sh[7:1]};
            bitn <= bitn + 1'b1;
            if (bitn == last_bit) st <= par_en ? ST_PAR : ST_STOP;
          end else if (samp_en) begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_PAR: begin
          if (full_tick) begin
            cnt  <= '0;
            pbit <= line;
            st   <= ST_STOP;
          end else if (samp_en) begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_STOP: begin
          if (full_tick) begin
            cnt  <= '0;
            done <= 1'b1;
            data <= aligned;
            pe   <= par_en & ((^aligned) ^ pbit ^ par_odd);
            fe   <= ~line;
            st   <= ST_IDLE;
          end else if (samp_en) begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_FALSE_START_IDLE: assert property (@(posedge clk) disable iff (rst)
    (st == ST_START && samp_en && cnt == half_m1 && line) |=> (st == ST_IDLE && !done)); // R3
  AST_DONE_AFTER_STOP: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(st) == ST_STOP); // R1
  AST_NO_PE_WITHOUT_PAR: assert property (@(posedge clk) disable iff (rst)
    (done && !par_en) |-> !pe); // R5
  AST_X1_SKIPS_START: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && samp_en && !line && is_x1) |=> st == ST_DATA); // R2
endmodule

// File: rtl/rx_hold_buf.sv
module rx_hold_buf #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          done,
  input  logic [DW-1:0] d_in,
  input  logic          pe_in,
  input  logic          fe_in,
  input  logic          rd_ack,
  input  logic          err_clr,
  output logic [DW-1:0] rx_data,
  output logic          rx_ready,
  output logic          par_err,
  output logic          frm_err,
  output logic          ovr_err
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_data  <= '0;
      rx_ready <= 1'b0;
      par_err  <= 1'b0;
      frm_err  <= 1'b0;
      ovr_err  <= 1'b0;
    end else begin
      if (done) begin
        rx_data  <= d_in;
        rx_ready <= 1'b1;
      end else if (rd_ack) begin
        rx_ready <= 1'b0;
      end

      if (done && rx_ready && !rd_ack) ovr_err <= 1'b1;
      else if (err_clr)                ovr_err <= 1'b0;

      if (done && pe_in)  par_err <= 1'b1;
      else if (err_clr)   par_err <= 1'b0;

      if (done && fe_in)  frm_err <= 1'b1;
      else if (err_clr)   frm_err <= 1'b0;
    end
  end

  AST_READY_ON_DONE: assert property (@(posedge clk) disable iff (rst)
    done |=> rx_ready); // R4
  AST_ACK_DROPS_READY: assert property (@(posedge clk) disable iff (rst)
    (rd_ack && !done) |=> !rx_ready); // R4
  AST_OVR_ON_FULL: assert property (@(posedge clk) disable iff (rst)
    (done && rx_ready && !rd_ack) |=> ovr_err); // R7
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !done |=> $stable(rx_data)); // R7
  AST_FE_STICKS: assert property (@(posedge clk) disable iff (rst)
    (done && fe_in) |=> frm_err); // R6
  AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (err_clr && !done) |=> (!par_err && !frm_err && !ovr_err)); // R8
endmodule

// File: rtl/rx_break_det.sv
module rx_break_det import rx_pkg::*; #(
  parameter int MID_DIV = 16,
  parameter int HI_DIV  = 64,
  parameter int DW      = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       samp_en,
  input  logic       line,
  input  logic [1:0] rate_sel,
  input  logic [1:0] char_len,
  input  logic       par_en,
  output logic       brk
);
  localparam int BW = $clog2(2 * (DW + 3) * HI_DIV + 1);

  logic [BW-1:0] cnt, thr, divv, frame;

  always_comb begin
    if (rate_sel == RATE_X1)       divv = BW'(1);
    else if (rate_sel == RATE_MID) divv = BW'(MID_DIV);
    else                           divv = BW'(HI_DIV);
    frame = BW'(char_len) + BW'(7) + BW'(par_en);
    thr   = (frame * divv) << 1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      brk <= 1'b0;
    end else if (line) begin
      cnt <= '0;
      brk <= 1'b0;
    end else if (samp_en && !brk) begin
      if (cnt == thr - 1'b1) brk <= 1'b1;
      else                   cnt <= cnt + 1'b1;
    end
  end

  AST_BRK_CLEARS_HIGH: assert property (@(posedge clk) disable iff (rst)
    line |=> !brk); // R9
  AST_BRK_NEEDS_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(brk) |-> !$past(line)); // R9
endmodule

// File: rtl/async_rx_core.sv
module async_rx_core #(
  parameter int MID_DIV     = 16,
  parameter int HI_DIV      = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       samp_en,
  input  logic       rxd,
  input  logic [1:0] rate_sel,
  input  logic [1:0] char_len,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic       rd_ack,
  input  logic       err_clr,
  output logic [7:0] rx_data,
  output logic       rx_ready,
  output logic       par_err,
  output logic       frm_err,
  output logic       ovr_err,
  output logic       brk_det
);
  localparam int DW = 8;

  logic          line_s;
  logic          fr_done, fr_pe, fr_fe;
  logic [DW-1:0] fr_data;

  rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .rxd(rxd), .rxd_s(line_s)
  );

  rx_frame_fsm #(.MID_DIV(MID_DIV), .HI_DIV(HI_DIV)) u_fsm (
    .clk(clk), .rst(rst), .samp_en(samp_en), .line(line_s),
    .rate_sel(rate_sel), .char_len(char_len), .par_en(par_en), .par_odd(par_odd),
    .done(fr_done), .data(fr_data), .pe(fr_pe), .fe(fr_fe)
  );

  rx_hold_buf #(.DW(DW)) u_buf (
    .clk(clk), .rst(rst), .done(fr_done), .d_in(fr_data), .pe_in(fr_pe), .fe_in(fr_fe),
    .rd_ack(rd_ack), .err_clr(err_clr), .rx_data(rx_data), .rx_ready(rx_ready),
    .par_err(par_err), .frm_err(frm_err), .ovr_err(ovr_err)
  );

  rx_break_det #(.MID_DIV(MID_DIV), .HI_DIV(HI_DIV), .DW(DW)) u_brk (
    .clk(clk), .rst(rst), .samp_en(samp_en), .line(line_s), .rate_sel(rate_sel),
    .char_len(char_len), .par_en(par_en), .brk(brk_det)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!rx_ready && !par_err && !frm_err && !ovr_err && !brk_det && rx_data == 8'h00)); // R10
endmodule

// File: tb/async_rx_core_bench.sv
module async_rx_core_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SE_PER     = 4;

  typedef struct packed {
    logic [7:0] data;
    logic       pe;
    logic       fe;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rxd = 1'b1;
  logic [1:0] rate_sel = 2'd1;
  logic [1:0] char_len = 2'd3;
  logic       par_en = 1'b0;
  logic       par_odd = 1'b0;
  logic       mon_ack = 1'b0;
  logic       man_ack = 1'b0;
  logic       err_clr = 1'b0;
  logic       mon_en = 1'b1;
  logic       samp_en;
  logic       rd_ack;
  logic [7:0] rx_data;
  logic       rx_ready, par_err, frm_err, ovr_err, brk_det;
  int         ph = 0;
  int         n_chk = 0;
  int         n_err = 0;
  exp_t       exp_q[$];

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) ph <= (ph == SE_PER - 1) ? 0 : ph + 1;
  assign samp_en = (ph == 0);
  assign rd_ack  = mon_ack | man_ack;

  async_rx_core u_async_rx_core (
    .clk(clk), .rst(rst), .samp_en(samp_en), .rxd(rxd), .rate_sel(rate_sel),
    .char_len(char_len), .par_en(par_en), .par_odd(par_odd), .rd_ack(rd_ack),
    .err_clr(err_clr), .rx_data(rx_data), .rx_ready(rx_ready), .par_err(par_err),
    .frm_err(frm_err), .ovr_err(ovr_err), .brk_det(brk_det)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Scoreboard monitor: pops an expected item each time a character is ready
  always @(negedge clk) begin
    if (mon_ack) mon_ack = 1'b0;
    else if (mon_en && rx_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R3 unexpected character", int'(rx_data), 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(rx_data == e.data, "R1 data", int'(rx_data), int'(e.data));
        check(par_err == e.pe, "R5 parity flag", int'(par_err), int'(e.pe));
        check(frm_err == e.fe, "R6 framing flag", int'(frm_err), int'(e.fe));
        check(!ovr_err, "R7 no overrun when read in time", int'(ovr_err), 0);
      end
      mon_ack = 1'b1;
    end
  end

  function automatic int cur_div();
    if (rate_sel == 2'd0) return 1;
    if (rate_sel == 2'd1) return 16;
    return 64;
  endfunction

  task automatic align();
    @(negedge clk);
    while (ph != 0) @(negedge clk);
  endtask

  task automatic hold_bit(input logic v);
    rxd = v;
    repeat (cur_div() * SE_PER) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input bit bad_par, input bit bad_stop);
    int nb;
    logic [7:0] m;
    logic p;
    exp_t e;
    nb = int'(char_len) + 5;
    m = d & 8'((1 << nb) - 1);
    p = (^m) ^ par_odd ^ bad_par;
    e.data = m;
    e.pe = par_en & bad_par;
    e.fe = bad_stop;
    if (mon_en) exp_q.push_back(e);
    align();
    hold_bit(1'b0);
    for (int i = 0; i < nb; i++) hold_bit(m[i]);
    if (par_en) hold_bit(p);
    hold_bit(!bad_stop);
    hold_bit(1'b1);
    hold_bit(1'b1);
  endtask

  task automatic pulse_clr();
    @(negedge clk) err_clr = 1'b1;
    @(negedge clk) err_clr = 1'b0;
  endtask

  task automatic pulse_ack();
    @(negedge clk) man_ack = 1'b1;
    @(negedge clk) man_ack = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    // R10 reset state
    check({rx_data, rx_ready, par_err, frm_err, ovr_err, brk_det} == 13'd0,
          "R10 reset outputs", int'({rx_data, rx_ready, par_err, frm_err, ovr_err, brk_det}), 0);

    // R1 R2: 8-bit characters at 16x
    rate_sel = 2'd1; char_len = 2'd3;
    send(8'hA5, 0, 0);
    send(8'h3C, 0, 0);
    // R1: shorter characters, upper bits must be zero
    char_len = 2'd0; send(8'hFF, 0, 0);
    char_len = 2'd1; send(8'h2B, 0, 0);
    char_len = 2'd2; send(8'h55, 0, 0);
    // R2: 1x and 64x rates
    char_len = 2'd3;
    rate_sel = 2'd0; send(8'h81, 0, 0); send(8'h7E, 0, 0);
    rate_sel = 2'd2; send(8'hC3, 0, 0);
    rate_sel = 2'd3; send(8'h19, 0, 0);
    rate_sel = 2'd1;
    // R5 parity even / odd, good and bad
    par_en = 1'b1; par_odd = 1'b0; send(8'h96, 0, 0);
    par_odd = 1'b1; send(8'h96, 0, 0);
    par_odd = 1'b0; send(8'h07, 1, 0); pulse_clr();
    check(!par_err, "R8 parity flag cleared", int'(par_err), 0);
    par_odd = 1'b1; send(8'h40, 1, 0); pulse_clr();
    par_en = 1'b0;
    // R6 framing error
    send(8'h5A, 0, 1); pulse_clr();
    check(!frm_err, "R8 framing flag cleared", int'(frm_err), 0);
    // R3 false start: short low pulse must not yield a character
    align();
    rxd = 1'b0; repeat (4 * SE_PER) @(negedge clk);
    rxd = 1'b1; repeat (12 * 16 * SE_PER) @(negedge clk);
    check(!rx_ready, "R3 false start produced no character", int'(rx_ready), 0);
    send(8'hE1, 0, 0);
    // R7 overrun, R8 clear, R4 ready held then acknowledged
    repeat (4) @(negedge clk);
    mon_en = 1'b0;
    send(8'h11, 0, 0);
    send(8'h22, 0, 0);
    check(rx_ready, "R4 ready held without read", int'(rx_ready), 1);
    check(ovr_err, "R7 overrun set", int'(ovr_err), 1);
    check(rx_data == 8'h22, "R7 newest character kept", int'(rx_data), 8'h22);
    pulse_clr();
    @(negedge clk);
    check(!ovr_err, "R8 overrun cleared", int'(ovr_err), 0);
    check(rx_ready, "R8 clear leaves ready", int'(rx_ready), 1);
    pulse_ack();
    check(!rx_ready, "R4 ack drops ready", int'(rx_ready), 0);
    // R9 break: 8N1 at 16x gives 2*10*16 = 320 sample periods
    align();
    rxd = 1'b0;
    repeat (316 * SE_PER) @(negedge clk);
    check(!brk_det, "R9 no break before threshold", int'(brk_det), 0);
    repeat (8 * SE_PER) @(negedge clk);
    check(brk_det, "R9 break after two frames", int'(brk_det), 1);
    rxd = 1'b1;
    repeat (4) @(negedge clk);
    check(!brk_det, "R9 break drops when line high", int'(brk_det), 0);
    repeat (24 * 16 * SE_PER) @(negedge clk);
    pulse_ack(); pulse_clr();
    mon_en = 1'b1;
    send(8'h6D, 0, 0);
    repeat (8) @(negedge clk);
    check(exp_q.size() == 0, "R4 all characters delivered", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule